// File: doc/BRIEF.md
# Programmable sample-strobe edge detector

This block sits between an external sampling-strobe pin and the timing controller that consumes it. In its conditioning mode it brings the strobe into the master-clock domain, watches for one chosen edge of it, and emits a single internal pulse one master-clock period wide. The pulse comes a programmable number of clocks after the edge.

In bypass mode the raw strobe level is forwarded through one output register. The edge logic, polarity and delay play no part in that path.

A new qualifying edge that arrives while a delayed pulse is still waiting restarts the wait. A burst of edges therefore yields exactly one pulse, timed from the last edge.

Top module: `strobe_conditioner`

## Requirements
- R1: With `det_en` = 0, `strobe_out` equals the value `strobe_in` had at the previous rising clock edge.
- R2: With `det_en` = 1 and `pol_rise` = 1, a 0-to-1 change of `strobe_in` produces one output pulse.
- R3: With `det_en` = 1 and `pol_rise` = 0, a 1-to-0 change of `strobe_in` produces one output pulse. A change in the opposite direction to the one selected produces no pulse.
- R4: The strobe is synchronised by two flops. If `strobe_in` changes just before rising edge k, `strobe_out` is high in the cycle that follows edge k+2+`dly`, where `dly` (3 bits, 0 to 7) is the extra delay in clocks.
- R5: In conditioning mode every pulse is exactly one clock period wide.
- R6: A selected edge that arrives while an earlier pulse is still pending reloads the delay. Only one pulse is emitted, timed from the later edge.
- R7: While `det_en` = 0, the values of `pol_rise` and `dly` have no effect on `strobe_out`.
- R8: Synchronous reset clears the synchroniser, the delay counter and `strobe_out`. A pulse pending at reset is never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_in | input | 1 | Raw strobe from the pin, asynchronous |
| det_en | input | 1 | 1 = edge-detect and delay, 0 = bypass |
| pol_rise | input | 1 | 1 = rising edge is detected, 0 = falling edge |
| dly | input | 3 | Extra delay in master-clock periods |
| strobe_out | output | 1 | Conditioned internal strobe, registered |

## Verification
A corrupted delay counter shows at the port as a pulse that comes early, comes late, comes twice, or never comes. The error is visible within at most ten clocks of the triggering edge. A faulty synchroniser or edge comparator shifts every pulse by a whole cycle, or makes the unselected edge fire, so the bench checks every cycle of a twelve-cycle window after each edge rather than only the expected one. Bypass faults show on the very next cycle as an output that does not track the pin.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q,
  output logic q_prev
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_prev <= 1'b0;
    else     q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_pick.sv
module edge_pick
  import strobe_pkg::*;
(
  input  logic q,
  input  logic q_prev,
  input  logic pol_rise,
  output logic hit
);
  edge_t seen;

  always_comb begin
    seen.rise = q & ~q_prev;
    seen.fall = ~q & q_prev;
    hit       = pol_rise ? seen.rise : seen.fall;
  end
endmodule

// File: rtl/pulse_delay.sv
module pulse_delay #(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hit,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)     cnt <= '0;
    else if (hit)       cnt <= dly;
    else if (cnt != '0) cnt <= cnt - ONE;
  end

  always_comb begin
    if (!en)      fire = 1'b0;
    else if (hit) fire = (dly == '0);
    else          fire = (cnt == ONE);
  end

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (en && hit) |=> (cnt == $past(dly)));

  // R4
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !hit && cnt != '0) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/strobe_conditioner.sv
module strobe_conditioner #(
  parameter int unsigned DLY_W  = 3,
  parameter int unsigned STAGES = strobe_pkg::SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_in,
  input  logic             det_en,
  input  logic             pol_rise,
  input  logic [DLY_W-1:0] dly,
  output logic             strobe_out
);
  logic s_now;
  logic s_prev;
  logic hit;
  logic fire;

  strobe_sync #(.STAGES(STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (strobe_in),
    .q      (s_now),
    .q_prev (s_prev)
  );

  edge_pick u_edge (
    .q        (s_now),
    .q_prev   (s_prev),
    .pol_rise (pol_rise),
    .hit      (hit)
  );

  pulse_delay #(.DLY_W(DLY_W)) u_delay (
    .clk  (clk),
    .rst  (rst),
    .en   (det_en),
    .hit  (hit),
    .dly  (dly),
    .fire (fire)
  );

  always_ff @(posedge clk) begin
    if (rst)         strobe_out <= 1'b0;
    else if (det_en) strobe_out <= fire;
    else             strobe_out <= strobe_in;
  end

  // R1
  bypass_track_chk: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> (strobe_out == $past(strobe_in)));

  // R5
  single_width_chk: assert property (@(posedge clk) disable iff (rst)
    (det_en && strobe_out) |=>
      (!det_en || !strobe_out || (pol_rise != $past(pol_rise))));
endmodule

// File: tb/strobe_conditioner_test.sv
module strobe_conditioner_test;
  localparam int PERIOD = 10;
  localparam int NV = 10;
  // each entry: {pol_rise, applied change is rising, dly[2:0]}
  localparam logic [4:0] VEC [NV] = '{
    5'b11_000, 5'b11_011, 5'b11_111, 5'b00_000, 5'b00_101,
    5'b00_111, 5'b10_010, 5'b01_100, 5'b11_001, 5'b00_110
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe_in = 1'b0;
  logic det_en = 1'b0;
  logic pol_rise = 1'b0;
  logic [2:0] dly = 3'd0;
  logic strobe_out;
  int total = 0;
  int bad = 0;

  strobe_conditioner uut (
    .clk(clk), .rst(rst), .strobe_in(strobe_in), .det_en(det_en),
    .pol_rise(pol_rise), .dly(dly), .strobe_out(strobe_out)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R2 R3 R4 R5: one edge, then every cycle of a 12-cycle window is checked
  task automatic run_case(input logic p, input logic rise, input logic [2:0] d);
    det_en = 1'b1; pol_rise = p; dly = d;
    strobe_in = ~rise;
    idle(12);
    strobe_in = rise;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      check(rise ? "R2/R4/R5" : "R3/R4/R5", strobe_out,
            (p == rise) && (i == 3 + int'(d)));
    end
  endtask

  initial begin
    idle(3);
    // R8: reset state
    check("R8", strobe_out, 1'b0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      run_case(VEC[v][4], VEC[v][3], VEC[v][2:0]);

    // R6: second rising edge while first pulse pending
    det_en = 1'b1; pol_rise = 1'b1; dly = 3'd7; strobe_in = 1'b0;
    idle(12);
    strobe_in = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (i == 2) strobe_in = 1'b0;
      if (i == 4) strobe_in = 1'b1;
      check("R6", strobe_out, i == 14);
    end

    // R8: reset drops a pending pulse
    strobe_in = 1'b0; idle(12);
    strobe_in = 1'b1; idle(5);
    rst = 1'b1; strobe_in = 1'b0; idle(2);
    check("R8", strobe_out, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      check("R8", strobe_out, 1'b0);
    end

    // R1 R7: bypass follows the pin whatever pol_rise and dly are
    det_en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pol_rise = i[0]; dly = 3'(i * 3);
      strobe_in = i[1] ^ i[2];
      @(negedge clk);
      check(i[0] ? "R7" : "R1", strobe_out, i[1] ^ i[2]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule